// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits behind the register decoder of a multi-queue storage controller and sees every write that lands in the doorbell window. Submission-queue tail doorbells and completion-queue head doorbells share one window. They are interleaved with an 8-byte stride per queue pair. Each write is turned into either a validated pointer update or a dropped-write report.

An accepted write produces a one-cycle update strobe in the cycle after the write is sampled. The strobe carries the queue kind, the queue id and the new 16-bit pointer. A rejected write produces a one-cycle drop strobe with a reason code instead. The per-queue "created" flags and the per-queue size tables come from the surrounding queue manager. Queue 0, the admin pair, exists exactly while the controller is enabled.

Top module: `qdb_decoder`

## Requirements
- R1: After reset, and until the first write, `updValid` and `dropValid` are low.
- R2: An aligned write to `DB_BASE + 8*q` for a queue q that exists, with data low 16 bits below that submission queue's size, gives `updValid` high in the next cycle, with `updIsCq`=0, `updQid`=q and `updPtr`=data[15:0].
- R3: An aligned write to `DB_BASE + 8*q + 4` for a queue q that exists, with data low 16 bits below that completion queue's size, gives `updValid` with `updIsCq`=1, `updQid`=q and `updPtr`=data[15:0] in the next cycle.
- R4: A write whose address has bits [1:0] not zero is dropped with `dropReason`=1, whatever its target.
- R5: An aligned write is dropped with `dropReason`=2 in three cases: the address is below `DB_BASE`, the queue id is not below `NUM_QUEUES`, or the queue's created flag is clear. The flag used is `sqLive[q]` for a submission doorbell and `cqLive[q]` for a completion doorbell.
- R6: An aligned write to an existing queue whose data[15:0] is greater than or equal to that queue's size is dropped with `dropReason`=3. A size is the 16-bit field `q` of `sqSizeTbl` or `cqSizeTbl`, bits [16q+15:16q].
- R7: Queue 0 of both kinds exists exactly when `ctrlEnable` is high. Bit 0 of `sqLive` and `cqLive` has no effect.
- R8: Every write yields exactly one outcome in the next cycle: an update or a drop, never both and never neither. The checks apply in the order R4, R5, R6.
- R9: A cycle with no write is followed by a cycle with both strobes low. Data bits [31:16] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A doorbell write is presented this cycle |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 32 | Write data; the low 16 bits are the new pointer |
| ctrlEnable | input | 1 | Controller enabled; makes queue 0 exist |
| sqLive | input | NUM_QUEUES | Submission queue created flags |
| cqLive | input | NUM_QUEUES | Completion queue created flags |
| sqSizeTbl | input | 16*NUM_QUEUES | Submission queue sizes, 16 bits per queue |
| cqSizeTbl | input | 16*NUM_QUEUES | Completion queue sizes, 16 bits per queue |
| updValid | output | 1 | One-cycle accepted-update strobe |
| updIsCq | output | 1 | 1 means completion head, 0 means submission tail |
| updQid | output | QID_W | Queue id of the update |
| updPtr | output | 16 | New pointer value |
| dropValid | output | 1 | One-cycle dropped-write strobe |
| dropReason | output | 2 | 1 misaligned, 2 nonexistent queue, 3 pointer out of range |

## Verification
The bench sweeps every byte address from just below the window to past its last queue pair. It does this under every combination of created flags and both enable states. Each address gets three pointer values: size minus one, exactly size, and zero. A design that compared with `>` instead of `>=` would accept the pointer equal to the size. A design that decoded the kind bit before checking alignment would report a misaligned write as a queue error. If queue 0 followed its created flag rather than the enable, the sweep would see updates while disabled. Upper data bits are set on accepted writes, so a design that took more than 16 bits would report the wrong pointer.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

  typedef enum logic [1:0] {
    DROP_NONE     = 2'd0,
    DROP_MISALIGN = 2'd1,
    DROP_NOQUEUE  = 2'd2,
    DROP_RANGE    = 2'd3
  } dropCode_e;

  // facts the datapath derives about the presented write
  typedef struct packed {
    logic misaligned;
    logic outside;
    logic live;
    logic ptrFits;
  } wrFacts_t;

  // control decision handed back to the datapath
  typedef struct packed {
    logic      take;
    logic      drop;
    dropCode_e why;
  } wrStrobe_t;

endpackage

// File: rtl/qdb_ctrl.sv
module qdb_ctrl
  import qdb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrValid,
  input  wrFacts_t  facts,
  output wrStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (wrValid) begin
      if (facts.misaligned) begin
        strobe.drop = 1'b1;
        strobe.why  = DROP_MISALIGN;
      end else if (facts.outside || !facts.live) begin
        strobe.drop = 1'b1;
        strobe.why  = DROP_NOQUEUE;
      end else if (!facts.ptrFits) begin
        strobe.drop = 1'b1;
        strobe.why  = DROP_RANGE;
      end else begin
        strobe.take = 1'b1;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $countones({strobe.take, strobe.drop}) == 1); // R8

  AST_NO_WRITE_NO_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |-> !strobe.take && !strobe.drop); // R9

endmodule

// File: rtl/qdb_datapath.sv
module qdb_datapath
  import qdb_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int PTR_W      = 16,
  parameter int DB_BASE    = 'h1000,
  parameter int QID_W      = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrValid,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        ctrlEnable,
  input  logic [NUM_QUEUES-1:0]       sqLive,
  input  logic [NUM_QUEUES-1:0]       cqLive,
  input  logic [NUM_QUEUES*PTR_W-1:0] sqSizeTbl,
  input  logic [NUM_QUEUES*PTR_W-1:0] cqSizeTbl,
  input  wrStrobe_t                   strobe,
  output wrFacts_t                    facts,
  output logic                        updValid,
  output logic                        updIsCq,
  output logic [QID_W-1:0]            updQid,
  output logic [PTR_W-1:0]            updPtr,
  output logic                        dropValid,
  output logic [1:0]                  dropReason
);

  localparam int QW_W = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(DB_BASE);

  logic [ADDR_W-1:0] offs;
  logic              belowBase;
  logic              kindCq;
  logic [QW_W-1:0]   qidWide;
  logic              qidOk;
  logic [QID_W-1:0]  qid;
  logic [PTR_W-1:0]  newPtr;
  logic [NUM_QUEUES-1:0] liveVec;
  logic [PTR_W-1:0]  sizeVec [NUM_QUEUES];
  logic              selLive;
  logic [PTR_W-1:0]  selSize;
  logic              unusedDataHi;

  assign offs      = wrAddr - BASE_A;
  assign belowBase = wrAddr < BASE_A;
  assign kindCq    = offs[2];
  assign qidWide   = offs[ADDR_W-1:3];
  assign qidOk     = !belowBase && (32'(qidWide) < NUM_QUEUES);
  assign qid       = qidWide[QID_W-1:0];
  assign newPtr    = wrData[PTR_W-1:0];
  assign unusedDataHi = ^wrData[DATA_W-1:PTR_W];

  // per-queue existence and size, selected by kind
  for (genvar gi = 0; gi < NUM_QUEUES; gi++) begin : g_queue
    if (gi == 0) begin : g_admin
      assign liveVec[gi] = ctrlEnable;
    end else begin : g_io
      assign liveVec[gi] = kindCq ? cqLive[gi] : sqLive[gi];
    end
    assign sizeVec[gi] = kindCq ? cqSizeTbl[gi*PTR_W +: PTR_W]
                                : sqSizeTbl[gi*PTR_W +: PTR_W];
  end

  always_comb begin
    selLive = 1'b0;
    selSize = '0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      if (qidOk && qid == QID_W'(i)) begin
        selLive = liveVec[i];
        selSize = sizeVec[i];
      end
    end
  end

  always_comb begin
    facts.misaligned = offs[1:0] != 2'b00;
    facts.outside    = !qidOk;
    facts.live       = selLive;
    facts.ptrFits    = newPtr < selSize;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updValid   <= 1'b0;
      updIsCq    <= 1'b0;
      updQid     <= '0;
      updPtr     <= '0;
      dropValid  <= 1'b0;
      dropReason <= DROP_NONE;
    end else begin
      updValid   <= strobe.take;
      dropValid  <= strobe.drop;
      dropReason <= strobe.why;
      if (strobe.take) begin
        updIsCq <= kindCq;
        updQid  <= qid;
        updPtr  <= newPtr;
      end
    end
  end

  AST_EXCLUSIVE_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !(updValid && dropValid)); // R8

  AST_UPD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrValid) |-> !updValid && !dropValid); // R9

  AST_UPD_PTR_FITS: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> updPtr < $past(selSize)); // R6

  AST_MISALIGN_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrValid && wrAddr[1:0] != 2'b00) |-> dropValid && dropReason == DROP_MISALIGN); // R4

  AST_ADMIN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    updValid && updQid == '0 |-> $past(ctrlEnable)); // R7

endmodule

// File: rtl/qdb_decoder.sv
module qdb_decoder
  import qdb_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int ADDR_W     = 16,
  parameter int DB_BASE    = 'h1000,
  localparam int DATA_W    = 32,
  localparam int PTR_W     = 16,
  localparam int QID_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrValid,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        ctrlEnable,
  input  logic [NUM_QUEUES-1:0]       sqLive,
  input  logic [NUM_QUEUES-1:0]       cqLive,
  input  logic [NUM_QUEUES*PTR_W-1:0] sqSizeTbl,
  input  logic [NUM_QUEUES*PTR_W-1:0] cqSizeTbl,
  output logic                        updValid,
  output logic                        updIsCq,
  output logic [QID_W-1:0]            updQid,
  output logic [PTR_W-1:0]            updPtr,
  output logic                        dropValid,
  output logic [1:0]                  dropReason
);

  wrFacts_t  facts;
  wrStrobe_t strobe;

  qdb_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrValid (wrValid),
    .facts   (facts),
    .strobe  (strobe)
  );

  qdb_datapath #(
    .NUM_QUEUES (NUM_QUEUES),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PTR_W      (PTR_W),
    .DB_BASE    (DB_BASE),
    .QID_W      (QID_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .ctrlEnable (ctrlEnable),
    .sqLive     (sqLive),
    .cqLive     (cqLive),
    .sqSizeTbl  (sqSizeTbl),
    .cqSizeTbl  (cqSizeTbl),
    .strobe     (strobe),
    .facts      (facts),
    .updValid   (updValid),
    .updIsCq    (updIsCq),
    .updQid     (updQid),
    .updPtr     (updPtr),
    .dropValid  (dropValid),
    .dropReason (dropReason)
  );

endmodule

// File: tb/qdb_decoder_tb.sv
module qdb_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NQ   = 4;
  localparam int AW   = 16;
  localparam int BASE = 'h1000;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic          ctrlEnable = 1'b0;
  logic [NQ-1:0] sqLive = '0;
  logic [NQ-1:0] cqLive = '0;
  logic [NQ*16-1:0] sqSizeTbl;
  logic [NQ*16-1:0] cqSizeTbl;
  logic          updValid, updIsCq, dropValid;
  logic [1:0]    updQid;
  logic [15:0]   updPtr;
  logic [1:0]    dropReason;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdb_decoder #(.NUM_QUEUES(NQ), .ADDR_W(AW), .DB_BASE(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlEnable(ctrlEnable), .sqLive(sqLive), .cqLive(cqLive),
    .sqSizeTbl(sqSizeTbl), .cqSizeTbl(cqSizeTbl),
    .updValid(updValid), .updIsCq(updIsCq), .updQid(updQid), .updPtr(updPtr),
    .dropValid(dropValid), .dropReason(dropReason)
  );

  function automatic int sqSz(int q); return 4 + q * 3; endfunction
  function automatic int cqSz(int q); return 3 + q * 5; endfunction

  task automatic fail(string req, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    wrValid = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (updValid !== 1'b0 || dropValid !== 1'b0)
      fail("R9", "strobe without write", {updValid, dropValid}, 0);
  endtask

  // one write, checked one cycle later against the arithmetic model
  task automatic doWrite(int addr, int data);
    int expUpd, expCq, expQ, expPtr, expWhy, off, sz, live;
    string req;
    expUpd = 0; expCq = 0; expQ = 0; expWhy = 0;
    expPtr = data & 'hFFFF;
    if ((addr & 3) != 0) begin
      expWhy = 1; req = "R4";
    end else if (addr < BASE) begin
      expWhy = 2; req = "R5";
    end else begin
      off = addr - BASE;
      expQ = off >> 3;
      expCq = (off >> 2) & 1;
      if (expQ >= NQ) begin
        expWhy = 2; req = "R5";
      end else begin
        live = (expQ == 0) ? int'(ctrlEnable)
             : (expCq ? int'(cqLive[expQ]) : int'(sqLive[expQ]));
        sz = expCq ? cqSz(expQ) : sqSz(expQ);
        if (live == 0) begin
          expWhy = 2; req = (expQ == 0) ? "R7" : "R5";
        end else if (expPtr >= sz) begin
          expWhy = 3; req = "R6";
        end else begin
          expUpd = 1;
          req = (expQ == 0) ? "R7" : (expCq ? "R3" : "R2");
        end
      end
    end
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = AW'(addr);
    wrData  = 32'(data);
    @(posedge clk); #1;
    checks++;
    if (updValid !== 1'(expUpd) || dropValid !== 1'(1 - expUpd))
      fail({req, "/R8"}, "outcome upd,drop", {updValid, dropValid}, {expUpd[0], ~expUpd[0]});
    else if (expUpd != 0) begin
      if (updIsCq !== 1'(expCq)) fail(req, "kind", updIsCq, expCq);
      else if (int'(updQid) != expQ) fail(req, "qid", updQid, expQ);
      else if (int'(updPtr) != expPtr) fail({req, "/R9"}, "pointer", updPtr, expPtr);
    end else if (int'(dropReason) != expWhy)
      fail(req, "reason", dropReason, expWhy);
    idleCheck();
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin
      sqSizeTbl[q*16 +: 16] = 16'(sqSz(q));
      cqSizeTbl[q*16 +: 16] = 16'(cqSz(q));
    end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (updValid !== 1'b0 || dropValid !== 1'b0)
      fail("R1", "strobes in reset", {updValid, dropValid}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (updValid !== 1'b0 || dropValid !== 1'b0)
      fail("R1", "strobes after reset", {updValid, dropValid}, 0);

    for (int en = 0; en < 2; en++) begin
      for (int pat = 0; pat < 16; pat++) begin
        @(negedge clk);
        ctrlEnable = en[0];
        sqLive = 4'(pat);
        cqLive = 4'(pat ^ 'hA);
        for (int a = BASE - 8; a < BASE + 8 * NQ + 8; a++) begin
          for (int ps = 0; ps < 3; ps++) begin
            int off, sz, cq, q;
            off = a - BASE;
            q  = (off < 0) ? 0 : off >> 3;
            cq = (off < 0) ? 0 : (off >> 2) & 1;
            if (q >= NQ) q = NQ - 1;
            sz = cq ? cqSz(q) : sqSz(q);
            case (ps)
              0: doWrite(a, 'hABCD0000 | (sz - 1));
              1: doWrite(a, sz);
              default: doWrite(a, 'h5A5A0000);
            endcase
          end
        end
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule